// File: doc/BRIEF.md
# Handshaked Parallel Port Controller

This block is an 8-bit parallel port that a host programs through a small register bus. A second handshake line sits beside a strobe line. The strobe line is always an input. The second line is either a further input or an output that the block drives itself. Each port pin has its own direction bit. Data read from the port comes either from a two-entry input buffer, filled by strobes, or straight from the pins. Data written to the port goes either directly to the pins or through a pending stage that a peripheral acknowledge releases.

Both handshake inputs pass through a synchronizer. Their polarity is then normalised by a sense bit before any edge is judged. An active edge sets a sticky status flag, and the host clears the flag by writing a 1 to it. The second line can be held negated, held asserted, run as an interlocked ready/available signal, or pulsed for a fixed number of cycles. A registered interrupt output combines the flags whose enables are set.

Register map (address: register): 0 general control, 1 port control, 2 direction, 3 data, 4 status. Unmapped addresses read as zero.

Top module: `hsk_port_ctrl`

## Requirements
- R1: After a synchronous reset every register, `bus_rdata`, `pin_out`, `pin_oe`, `hs_b_out`, `hs_b_oe` and `irq` are zero.
- R2: A write with `bus_sel` and `bus_wr` stores `bus_wdata` in the addressed register. A read with `bus_sel` and `bus_rd` loads `bus_rdata` on that clock edge and holds it otherwise. Bit i of the direction register (address 2) set to 1 drives `pin_oe[i]` high from the next cycle.
- R3: Each handshake input passes two flops and is then made active-high using general control bit 0 (strobe line) or bit 1 (second line), where 1 means active high. An active edge acts on the third rising clock edge after the pin changes.
- R4: With port control bits 7:6 = 00, an enabled active strobe edge pushes `pin_in` into a two-entry buffer. A data read pops the oldest entry. A strobe meeting a full buffer with no pop in the same cycle is dropped. Input bits read as zero when the buffer is empty.
- R5: With port control bits 7:6 = 01 or 1x, data reads return `pin_in` live on input bits. On every submode, bits whose direction is 1 read back the output latch.
- R6: With port control bits 7:6 other than 01, a data write reaches `pin_out` on the next cycle.
- R7: With port control bits 7:6 = 01, a data write while the output latch holds unacknowledged data is kept pending. An enabled active strobe edge (the acknowledge) moves it to `pin_out`. A write to an already occupied pending stage replaces it.
- R8: Status bit 4 is the active level of the strobe line. Bit 5 is the active level of the second line, or its driven asserted state when it is an output. Bit 0 is set by an enabled strobe edge. Bit 1 is set by an enabled edge of the second line while port control bit 5 is 0. Writing 1 to bit 0 or bit 1 clears it, except that a set in the same cycle wins.
- R9: Port control bits 5:3 select the second line: 0xx makes it an input (`hs_b_oe` low), 100 drives it negated, and 101 drives it asserted. `hs_b_out` is high when asserted if general control bit 1 is 1, and low when asserted otherwise.
- R10: In mode 110 the second line is asserted while the input buffer has room (submode 00), or while the output latch holds unacknowledged data (other submodes).
- R11: In mode 111 the second line is asserted for exactly PULSE_LEN cycles (default 4) after a data read (submode 00) or after a load of the output latch (other submodes).
- R12: `irq` is the registered OR of flag 0 when port control bits 1:0 = 10 and flag 1 when port control bit 2 = 1.
- R13: With general control bit 4 = 0, handshake edges set no flag, latch no data and give no acknowledge, and the second line is driven negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| pin_in | input | W | Port pins as seen from outside |
| pin_out | output | W | Output latch driven onto the pins |
| pin_oe | output | W | Per-pin output enable |
| hs_a_in | input | 1 | Strobe / acknowledge handshake input |
| hs_b_in | input | 1 | Second handshake line, input side |
| hs_b_out | output | 1 | Second handshake line, driven value |
| hs_b_oe | output | 1 | Second handshake line output enable |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can meet in one clock. The first is a strobe edge that sets flag 0 and a host write-1-to-clear of that flag. The second is a strobe push into the input buffer and a host pop from it. The bench provokes the first case by starting the bus write two cycles after it drops the strobe line, so that the write lands on the same edge as the synchronized edge. It then reads status and requires the flag to stay set. A behavioural model, built on a byte queue and integers, steps every clock with the same stimulus and judges all outputs and read data each cycle. Any coincidence of these kinds is therefore checked against the stated priorities.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [2:0] {
    RA_GCTL = 3'd0,
    RA_PCTL = 3'd1,
    RA_DDIR = 3'd2,
    RA_DATA = 3'd3,
    RA_STAT = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    L2_NEG   = 2'b00,
    L2_ASRT  = 2'b01,
    L2_LOCK  = 2'b10,
    L2_PULSE = 2'b11
  } l2_out_e;

  localparam int NUM_LINES = 2;
  localparam logic [1:0] SUB_DBL_IN  = 2'b00;
  localparam logic [1:0] SUB_DBL_OUT = 2'b01;
endpackage

// File: rtl/hsk_sync_edge.sv
module hsk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic sense_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], raw_i};
      prev_q <= level_o;
    end
  end

  // polarity is applied before the edge is judged
  assign level_o = sense_i ? sh_q[STAGES-1] : ~sh_q[STAGES-1];
  assign edge_o  = level_o & ~prev_q;
endmodule

// File: rtl/hsk_in_buf.sv
module hsk_in_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] head_o,
  output logic [1:0]   cnt_o
);
  localparam int DEPTH = 2;

  logic [W-1:0] slot_q [DEPTH];
  logic [1:0]   cnt_q;
  logic         pop_ok, push_ok;
  logic [1:0]   wr_idx;

  assign pop_ok  = pop_i && (cnt_q != 2'd0);
  assign push_ok = push_i && ((cnt_q != 2'(DEPTH)) || pop_ok);
  assign wr_idx  = cnt_q - {1'b0, pop_ok};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      cnt_q <= 2'd0;
    end else begin
      if (pop_ok) slot_q[0] <= slot_q[1];
      if (push_ok) slot_q[wr_idx[0]] <= din_i;
      cnt_q <= cnt_q + {1'b0, push_ok} - {1'b0, pop_ok};
    end
  end

  assign head_o = (cnt_q != 2'd0) ? slot_q[0] : '0;
  assign cnt_o  = cnt_q;

  AST_IN_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && cnt_q == 2'd2) |=> (cnt_q == 2'd2 && head_o == $past(head_o))); // R4
endmodule

// File: rtl/hsk_out_buf.sv
module hsk_out_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dbl_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ack_i,
  output logic [W-1:0] lat_o,
  output logic         avail_o,
  output logic         load_o
);
  logic [W-1:0] lat_q, pend_q, lat_d, pend_d;
  logic         ov_q, pv_q, ov_d, pv_d;

  always_comb begin
    lat_d  = lat_q;
    pend_d = pend_q;
    ov_d   = ov_q;
    pv_d   = pv_q;
    load_o = 1'b0;
    if (ack_i) begin
      if (dbl_i && pv_q) begin
        lat_d  = pend_q;
        pv_d   = 1'b0;
        load_o = 1'b1;
      end else begin
        ov_d = 1'b0;
      end
    end
    if (wr_i) begin
      if (!dbl_i || !ov_d) begin
        lat_d  = wdata_i;
        ov_d   = 1'b1;
        load_o = 1'b1;
      end else begin
        pend_d = wdata_i;
        pv_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      pend_q <= '0;
      ov_q   <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      pend_q <= pend_d;
      ov_q   <= ov_d;
      pv_q   <= pv_d;
    end
  end

  assign lat_o   = lat_q;
  assign avail_o = ov_q;

  AST_SB_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !dbl_i) |=> (lat_o == $past(wdata_i))); // R6
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_i && dbl_i && ov_q && !ack_i) |=> $stable(lat_o)); // R7
endmodule

// File: rtl/hsk_line_ctl.sv
module hsk_line_ctl import hsk_pkg::*; #(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic       in_role_i,
  input  logic       in_ready_i,
  input  logic       out_avail_i,
  input  logic       trig_i,
  input  logic       sense_i,
  output logic       asrt_o,
  output logic       line_o,
  output logic       oe_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] pcnt_q;
  logic             asrt_d;

  always_ff @(posedge clk) begin
    if (rst)                  pcnt_q <= '0;
    else if (trig_i)          pcnt_q <= CNT_W'(PULSE_LEN);
    else if (pcnt_q != '0)    pcnt_q <= pcnt_q - 1'b1;
  end

  always_comb begin
    asrt_d = 1'b0;
    if (en_i && mode_i[2]) begin
      case (l2_out_e'(mode_i[1:0]))
        L2_NEG:   asrt_d = 1'b0;
        L2_ASRT:  asrt_d = 1'b1;
        L2_LOCK:  asrt_d = in_role_i ? in_ready_i : out_avail_i;
        default:  asrt_d = (pcnt_q != '0);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asrt_o <= 1'b0;
      line_o <= 1'b0;
      oe_o   <= 1'b0;
    end else begin
      asrt_o <= asrt_d;
      line_o <= sense_i ? asrt_o : ~asrt_o;
      oe_o   <= mode_i[2];
    end
  end

  AST_DIS_NEG: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !asrt_o); // R13
  AST_PULSE_DEC: assert property (@(posedge clk) disable iff (rst)
    (pcnt_q != '0 && !trig_i) |=> (pcnt_q == $past(pcnt_q) - 1'b1)); // R11
endmodule

// File: rtl/hsk_port_ctrl.sv
module hsk_port_ctrl import hsk_pkg::*; #(
  parameter int W           = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  input  logic              hs_a_in,
  input  logic              hs_b_in,
  output logic              hs_b_out,
  output logic              hs_b_oe,
  output logic              irq
);
  logic [W-1:0] gctl_q, pctl_q, ddir_q, rdata_q;
  logic [1:0]   flag_q;
  logic         irq_q;

  // line 0 = strobe, line 1 = second handshake line
  logic [NUM_LINES-1:0] raw_ln, lvl_ln, edg_ln, sense_ln;
  assign raw_ln   = {hs_b_in, hs_a_in};
  assign sense_ln = gctl_q[1:0];

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    hsk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (raw_ln[gi]),
      .sense_i (sense_ln[gi]),
      .level_o (lvl_ln[gi]),
      .edge_o  (edg_ln[gi])
    );
  end

  logic       hs_en, in_role, dbl_out;
  logic [1:0] submode;
  logic [2:0] l2_mode;
  assign hs_en   = gctl_q[4];
  assign submode = pctl_q[7:6];
  assign l2_mode = pctl_q[5:3];
  assign in_role = (submode == SUB_DBL_IN);
  assign dbl_out = (submode == SUB_DBL_OUT);

  logic ev1, ev2;
  assign ev1 = edg_ln[0] & hs_en;
  assign ev2 = edg_ln[1] & hs_en & ~l2_mode[2];

  logic acc_wr, acc_rd, wr_gctl, wr_pctl, wr_ddir, wr_data, wr_stat, rd_data;
  assign acc_wr  = bus_sel & bus_wr;
  assign acc_rd  = bus_sel & bus_rd;
  assign wr_gctl = acc_wr && (bus_addr == ADDR_W'(RA_GCTL));
  assign wr_pctl = acc_wr && (bus_addr == ADDR_W'(RA_PCTL));
  assign wr_ddir = acc_wr && (bus_addr == ADDR_W'(RA_DDIR));
  assign wr_data = acc_wr && (bus_addr == ADDR_W'(RA_DATA));
  assign wr_stat = acc_wr && (bus_addr == ADDR_W'(RA_STAT));
  assign rd_data = acc_rd && (bus_addr == ADDR_W'(RA_DATA));

  logic [W-1:0] in_head, lat;
  logic [1:0]   in_cnt;
  logic         out_avail, load_ev, asrt;

  hsk_in_buf #(.W(W)) u_in_buf (
    .clk    (clk),
    .rst    (rst),
    .push_i (ev1 & in_role),
    .pop_i  (rd_data & in_role),
    .din_i  (pin_in),
    .head_o (in_head),
    .cnt_o  (in_cnt)
  );

  hsk_out_buf #(.W(W)) u_out_buf (
    .clk     (clk),
    .rst     (rst),
    .dbl_i   (dbl_out),
    .wr_i    (wr_data),
    .wdata_i (bus_wdata),
    .ack_i   (ev1 & ~in_role),
    .lat_o   (lat),
    .avail_o (out_avail),
    .load_o  (load_ev)
  );

  hsk_line_ctl #(.PULSE_LEN(PULSE_LEN)) u_line_ctl (
    .clk         (clk),
    .rst         (rst),
    .en_i        (hs_en),
    .mode_i      (l2_mode),
    .in_role_i   (in_role),
    .in_ready_i  (in_cnt != 2'd2),
    .out_avail_i (out_avail),
    .trig_i      (in_role ? rd_data : load_ev),
    .sense_i     (gctl_q[1]),
    .asrt_o      (asrt),
    .line_o      (hs_b_out),
    .oe_o        (hs_b_oe)
  );

  logic [W-1:0] in_val, data_val, stat_val;
  assign in_val   = in_role ? in_head : pin_in;
  assign data_val = (ddir_q & lat) | (~ddir_q & in_val);
  assign stat_val = W'({2'b00, (l2_mode[2] ? asrt : lvl_ln[1]), lvl_ln[0], 2'b00, flag_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_q <= '0;
      pctl_q <= '0;
      ddir_q <= '0;
    end else begin
      if (wr_gctl) gctl_q <= bus_wdata;
      if (wr_pctl) pctl_q <= bus_wdata;
      if (wr_ddir) ddir_q <= bus_wdata;
    end
  end

  // a set from an edge wins over a write-1 clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      flag_q[0] <= (flag_q[0] & ~(wr_stat & bus_wdata[0])) | ev1;
      flag_q[1] <= (flag_q[1] & ~(wr_stat & bus_wdata[1])) | ev2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= (flag_q[0] && pctl_q[1:0] == 2'b10) || (flag_q[1] && pctl_q[2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (acc_rd) begin
      case (bus_addr)
        ADDR_W'(RA_GCTL): rdata_q <= gctl_q;
        ADDR_W'(RA_PCTL): rdata_q <= pctl_q;
        ADDR_W'(RA_DDIR): rdata_q <= ddir_q;
        ADDR_W'(RA_DATA): rdata_q <= data_val;
        ADDR_W'(RA_STAT): rdata_q <= stat_val;
        default:          rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = lat;
  assign pin_oe    = ddir_q;
  assign irq       = irq_q;

  AST_DDIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_ddir |=> (pin_oe == $past(bus_wdata))); // R2
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && bus_wdata[0] && !ev1) |=> !flag_q[0]); // R8
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev1 |=> flag_q[0]); // R8
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flag_q[0] && pctl_q[1:0] == 2'b10) |=> irq); // R12
endmodule

// File: tb/test_hsk_port_ctrl.sv
`timescale 1ns/1ps
module test_hsk_port_ctrl;
  localparam int PL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pin_in = '0;
  logic       hs_a_in = 1'b1, hs_b_in = 1'b1;
  logic [7:0] bus_rdata, pin_out, pin_oe;
  logic       hs_b_out, hs_b_oe, irq;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hsk_port_ctrl #(.PULSE_LEN(PL)) i_hsk_port_ctrl (
    .clk, .rst, .bus_sel, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .pin_in, .pin_out, .pin_oe, .hs_a_in, .hs_b_in, .hs_b_out, .hs_b_oe, .irq
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_gc, m_pc, m_dd, m_lat, m_pend, m_rd;
  logic       m_ov, m_pv, m_as, m_hbo, m_oe, m_irq, m_pa, m_pb;
  logic [1:0] m_f, m_sa, m_sb;
  logic [7:0] m_q[$];
  int         m_pul;

  always @(posedge clk) begin
    logic acta, actb, e1, e2, en, rdd, wrd, wst, ld, trig, pop, n_as;
    logic [1:0] sub;
    logic [2:0] l2;
    logic [7:0] inv, st;
    if (rst) begin
      m_gc = 0; m_pc = 0; m_dd = 0; m_lat = 0; m_pend = 0; m_rd = 0;
      m_ov = 0; m_pv = 0; m_as = 0; m_hbo = 0; m_oe = 0; m_irq = 0;
      m_pa = 0; m_pb = 0; m_f = 0; m_sa = 0; m_sb = 0; m_q.delete(); m_pul = 0;
    end else begin
      acta = m_gc[0] ? m_sa[1] : ~m_sa[1];
      actb = m_gc[1] ? m_sb[1] : ~m_sb[1];
      en = m_gc[4]; sub = m_pc[7:6]; l2 = m_pc[5:3];
      e1 = acta & ~m_pa & en;
      e2 = actb & ~m_pb & en & ~l2[2];
      rdd = bus_sel & bus_rd & (bus_addr == 3);
      wrd = bus_sel & bus_wr & (bus_addr == 3);
      wst = bus_sel & bus_wr & (bus_addr == 4);
      inv = (sub == 0) ? ((m_q.size() > 0) ? m_q[0] : 8'h00) : pin_in;
      st  = {2'b00, (l2[2] ? m_as : actb), acta, 2'b00, m_f};
      if (bus_sel & bus_rd)
        case (bus_addr)
          0: m_rd = m_gc; 1: m_rd = m_pc; 2: m_rd = m_dd;
          3: m_rd = (m_dd & m_lat) | (~m_dd & inv);
          4: m_rd = st; default: m_rd = 0;
        endcase
      n_as = en && l2[2] && (l2[1:0] == 2'b01 ||
             (l2[1:0] == 2'b10 && ((sub == 0) ? (m_q.size() < 2) : m_ov)) ||
             (l2[1:0] == 2'b11 && m_pul != 0));
      m_irq = (m_f[0] && m_pc[1:0] == 2'b10) || (m_f[1] && m_pc[2]);
      m_hbo = m_gc[1] ? m_as : ~m_as;
      m_oe  = m_pc[5];
      // input queue
      pop = rdd && sub == 0 && m_q.size() > 0;
      if (pop) void'(m_q.pop_front());
      if (e1 && sub == 0 && m_q.size() < 2) m_q.push_back(pin_in);
      // output latch
      ld = 0;
      if (e1 && sub != 0) begin
        if (sub == 1 && m_pv) begin m_lat = m_pend; m_pv = 0; ld = 1; end
        else m_ov = 0;
      end
      if (wrd) begin
        if (sub != 1 || !m_ov) begin m_lat = bus_wdata; m_ov = 1; ld = 1; end
        else begin m_pend = bus_wdata; m_pv = 1; end
      end
      trig = (sub == 0) ? rdd : ld;
      if (trig) m_pul = PL; else if (m_pul > 0) m_pul--;
      m_as = n_as;
      m_f[0] = (m_f[0] & ~(wst & bus_wdata[0])) | e1;
      m_f[1] = (m_f[1] & ~(wst & bus_wdata[1])) | e2;
      if (bus_sel & bus_wr & bus_addr == 0) m_gc = bus_wdata;
      if (bus_sel & bus_wr & bus_addr == 1) m_pc = bus_wdata;
      if (bus_sel & bus_wr & bus_addr == 2) m_dd = bus_wdata;
      m_sa = {m_sa[0], hs_a_in}; m_pa = acta;
      m_sb = {m_sb[0], hs_b_in}; m_pb = actb;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 pin_out model", pin_out, m_lat);
      chk("R2 pin_oe model", pin_oe, m_dd);
      chk("R2 rdata model", bus_rdata, m_rd);
      chk("R9 hs_b_out model", {7'd0, hs_b_out}, {7'd0, m_hbo});
      chk("R9 hs_b_oe model", {7'd0, hs_b_oe}, {7'd0, m_oe});
      chk("R12 irq model", {7'd0, irq}, {7'd0, m_irq});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic strobe_a();
    @(negedge clk); hs_a_in = 0;
    idle(5);
    hs_a_in = 1;
    idle(5);
  endtask

  task automatic strobe_b();
    @(negedge clk); hs_b_in = 0;
    idle(5);
    hs_b_in = 1;
    idle(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int lows;
    idle(4);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 hs_b_oe", {7'd0, hs_b_oe}, 8'h00);
    rd_reg(0, d); chk("R1 gctl", d, 8'h00);
    rd_reg(4, d); chk("R1 status", d, 8'h00);
    // R2 direction register
    wr_reg(2, 8'hF0);
    chk("R2 pin_oe", pin_oe, 8'hF0);
    rd_reg(2, d); chk("R2 ddir readback", d, 8'hF0);
    rd_reg(6, d); chk("R2 unmapped", d, 8'h00);
    wr_reg(2, 8'h00);
    // R4 double-buffered input, R8 flag
    wr_reg(0, 8'h10);
    wr_reg(1, 8'h00);
    wr_reg(4, 8'h03);
    pin_in = 8'hA5; strobe_a();
    rd_reg(4, d); chk("R8 flag0 set", d, 8'h01);
    pin_in = 8'h3C; strobe_a();
    pin_in = 8'h77; strobe_a();
    rd_reg(3, d); chk("R4 first entry", d, 8'hA5);
    rd_reg(3, d); chk("R4 second entry", d, 8'h3C);
    rd_reg(3, d); chk("R4 third dropped", d, 8'h00);
    wr_reg(4, 8'h01);
    rd_reg(4, d); chk("R8 w1c", d, 8'h00);
    // R3 + R12 timing of strobe to irq
    wr_reg(1, 8'h02);
    idle(3);
    @(negedge clk); hs_a_in = 0;
    idle(3); chk("R3 no action before third edge", {7'd0, irq}, 8'h00);
    idle(1); chk("R12 irq after flag", {7'd0, irq}, 8'h01);
    hs_a_in = 1; idle(4);
    wr_reg(4, 8'h01); idle(2);
    chk("R12 irq cleared", {7'd0, irq}, 8'h00);
    // R8 line2 input flag
    wr_reg(1, 8'h04);
    strobe_b();
    rd_reg(4, d); chk("R8 flag1 set", d, 8'h02);
    chk("R12 irq from flag1", {7'd0, irq}, 8'h01);
    wr_reg(4, 8'h02);
    // R3 sense bit
    wr_reg(0, 8'h11); idle(4);
    rd_reg(4, d); chk("R3 active-high level", {7'd0, d[4]}, 8'h01);
    wr_reg(0, 8'h10); idle(4);
    wr_reg(4, 8'h03);
    // R5 non-latched input
    wr_reg(1, 8'h40);
    wr_reg(2, 8'h0F);
    wr_reg(3, 8'h5A);
    chk("R7 first write to pins", pin_out, 8'h5A);
    pin_in = 8'hC3;
    rd_reg(3, d); chk("R5 live mix", d, 8'hCA);
    // R7 double-buffered output
    wr_reg(3, 8'h11);
    chk("R7 pending holds", pin_out, 8'h5A);
    strobe_a();
    chk("R7 ack releases", pin_out, 8'h11);
    strobe_a();
    // R10 output-role interlock
    wr_reg(1, 8'h70); idle(3);
    chk("R10 out idle negated", {7'd0, hs_b_out}, 8'h01);
    wr_reg(3, 8'h22); idle(3);
    chk("R10 out data available", {7'd0, hs_b_out}, 8'h00);
    strobe_a();
    chk("R10 out acked", {7'd0, hs_b_out}, 8'h01);
    // R6 single-buffered
    wr_reg(1, 8'h80);
    wr_reg(3, 8'h99);
    chk("R6 direct write", pin_out, 8'h99);
    // R9 fixed modes
    wr_reg(1, 8'h20); idle(3);
    chk("R9 oe", {7'd0, hs_b_oe}, 8'h01);
    chk("R9 negated low-active", {7'd0, hs_b_out}, 8'h01);
    wr_reg(1, 8'h28); idle(3);
    chk("R9 asserted low-active", {7'd0, hs_b_out}, 8'h00);
    wr_reg(0, 8'h12); idle(3);
    chk("R9 asserted high-active", {7'd0, hs_b_out}, 8'h01);
    wr_reg(0, 8'h10);
    wr_reg(1, 8'h00); idle(3);
    chk("R9 input oe", {7'd0, hs_b_oe}, 8'h00);
    // R10 input-role interlock
    wr_reg(2, 8'h00);
    wr_reg(1, 8'h30);
    for (int i = 0; i < 3; i++) rd_reg(3, d);
    idle(3);
    chk("R10 ready with room", {7'd0, hs_b_out}, 8'h00);
    strobe_a(); strobe_a();
    chk("R10 not ready when full", {7'd0, hs_b_out}, 8'h01);
    rd_reg(3, d); idle(3);
    chk("R10 ready after read", {7'd0, hs_b_out}, 8'h00);
    rd_reg(3, d);
    // R11 pulsed
    wr_reg(1, 8'h38); idle(8);
    rd_reg(3, d);
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!hs_b_out) lows++;
    end
    chk("R11 pulse width", 8'(lows), 8'(PL));
    // R13 disabled handshakes
    wr_reg(0, 8'h00);
    wr_reg(1, 8'h28); idle(3);
    chk("R13 line negated", {7'd0, hs_b_out}, 8'h01);
    wr_reg(4, 8'h03);
    strobe_a();
    rd_reg(4, d); chk("R13 no flag", d, 8'h00);
    // R8 set wins over clear in the same cycle
    wr_reg(0, 8'h10);
    wr_reg(1, 8'h00); idle(4);
    wr_reg(4, 8'h03);
    @(negedge clk); hs_a_in = 0;
    idle(2);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd4; bus_wdata = 8'h01;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    hs_a_in = 1; idle(4);
    rd_reg(4, d); chk("R8 set beats clear", d, 8'h01);
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule